// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block stores incoming Ethernet frames into an on-chip packet memory that is organised as a circular ring of 256-byte pages. Software programs four page numbers through a small register port: the first page of the ring, the page one past its last page, the boundary page (the oldest page the consumer still owns) and the current page (where the next frame will land). Frames come in as a byte stream with a valid/ready handshake, a last-byte flag and a length field that is valid with the first byte.

For each frame the block first decides whether there is room and whether reception is halted. A refused frame is consumed and discarded without touching memory. An accepted frame is placed at the start of the current page behind a 4-byte header holding a status byte, the page number where the following frame will start, and the stored length. The payload follows the header, wrapping from the end of the ring back to its first page. Short frames are padded with zeros. When the frame is complete the current page moves to the next free page and a one-cycle done event is raised together with the frame's status byte. A plain synchronous read port onto the packet memory is provided for the consumer side.

Top module: `rxring_writer`

## Requirements
- R1: Register select 0 holds the ring's first page, 1 the page past its last page, 2 the boundary page, 3 the current page; `cfg_rdata` returns the selected register one cycle after `cfg_sel` is set. Writes to selects 0 and 1 take effect only when the value is at most PAGES; writes to selects 2 and 3 only when the value is below PAGES; other writes leave the register unchanged.
- R2: When the last-page register is not above the first-page register, a frame is refused: all its bytes are consumed, no memory byte changes, no done event occurs and the current page is unchanged.
- R3: A frame is also refused when free space is under 1518 bytes, where free space in pages is (boundary − current) if current < boundary, else (last − first) − (current − boundary), times 256.
- R4: A frame that starts while `halt` is high is refused in the same way.
- R5: An accepted frame writes, at byte address current×256, the header bytes in order: status, next page, stored length low byte, stored length high byte, where stored length is max(frame length, 60) + 4; the payload follows at the next address.
- R6: The status byte has bit 0 set, bit 5 set exactly when bit 0 of the first frame byte is set, and all other bits clear; it also appears on `rx_status` with the done event.
- R7: A frame shorter than 60 bytes is followed by zero bytes until 60 payload bytes have been stored; a frame of 60 bytes or more gets no padding.
- R8: Whenever the write address would reach last×256 it continues at first×256.
- R9: The next page is current + floor((stored length + 4 + 255) / 256), minus (last − first) when that reaches or passes the last page; after the frame, the current page takes this value and `rx_done` is high for exactly one cycle.
- R10: `in_ready` is low while the block is idle and while it writes the header (so an accepted frame waits five cycles before its first byte is taken, a refused one one cycle), and high while payload bytes are taken or a refused frame is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for write and read |
| cfg_wdata | input | 8 | Register write value (page number) |
| cfg_rdata | output | 8 | Selected register, registered |
| halt | input | 1 | Refuse frames that start while high |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Frame byte taken when high with in_valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_len | input | LEN_W (11) | Frame length in bytes, valid with the first byte |
| mem_raddr | input | ADDR_W (11) | Packet memory read address |
| mem_rdata | output | 8 | Packet memory read data, one cycle later |
| rx_done | output | 1 | One-cycle pulse after a frame is stored |
| rx_status | output | 8 | Status byte of the last stored frame |

## Verification
A wrong space decision shows up within the first cycle of a frame as the wrong number of stall cycles on `in_ready`, and later as a missing or extra done pulse. A wrong header or wrap address corrupts packet memory silently, so the bench keeps a byte image of what each frame should have written and reads the ring back after every frame, including after refused frames placed over live data. A wrong next-page value is visible on the current-page register right after the done pulse, and compounds into misplaced later frames.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HDR,
    S_DATA,
    S_PAD,
    S_FIN,
    S_DROP
  } wr_state_e;

  localparam logic [1:0] SEL_FIRST = 2'd0;
  localparam logic [1:0] SEL_LAST  = 2'd1;
  localparam logic [1:0] SEL_BND   = 2'd2;
  localparam logic [1:0] SEL_CUR   = 2'd3;

  localparam logic [7:0] STAT_GOOD  = 8'h01;
  localparam logic [7:0] STAT_GROUP = 8'h20;

  localparam int HDR_BYTES = 4;
  localparam int TRAIL_BYTES = 4;

endpackage

// File: rtl/rxring_regs.sv
module rxring_regs
  import rxring_pkg::*;
#(
  parameter int PAGES = 8,
  parameter int PG_W  = 4
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [1:0]      sel,
  input  logic [7:0]      wdata,
  input  logic            load_cur,
  input  logic [PG_W-1:0] cur_nxt,
  output logic [PG_W-1:0] first_pg,
  output logic [PG_W-1:0] last_pg,
  output logic [PG_W-1:0] bnd_pg,
  output logic [PG_W-1:0] cur_pg,
  output logic [7:0]      rdata
);

  localparam logic [7:0] LIMIT = 8'(PAGES);
  localparam int EXT = 8 - PG_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_pg <= '0;
      last_pg  <= '0;
      bnd_pg   <= '0;
      cur_pg   <= '0;
      rdata    <= '0;
    end else begin
      if (we) begin
        case (sel)
          SEL_FIRST: if (wdata <= LIMIT) first_pg <= wdata[PG_W-1:0];
          SEL_LAST:  if (wdata <= LIMIT) last_pg  <= wdata[PG_W-1:0];
          SEL_BND:   if (wdata <  LIMIT) bnd_pg   <= wdata[PG_W-1:0];
          default:   if (wdata <  LIMIT) cur_pg   <= wdata[PG_W-1:0];
        endcase
      end
      if (load_cur) cur_pg <= cur_nxt;
      case (sel)
        SEL_FIRST: rdata <= {{EXT{1'b0}}, first_pg};
        SEL_LAST:  rdata <= {{EXT{1'b0}}, last_pg};
        SEL_BND:   rdata <= {{EXT{1'b0}}, bnd_pg};
        default:   rdata <= {{EXT{1'b0}}, cur_pg};
      endcase
    end
  end

  p_last_filter_r1: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_LAST && wdata > LIMIT) |=> $stable(last_pg))
    else $error("out-of-range last-page write took effect");

  p_bnd_filter_r1: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_BND && wdata >= LIMIT) |=> $stable(bnd_pg))
    else $error("out-of-range boundary write took effect");

endmodule

// File: rtl/rxring_space.sv
module rxring_space
  import rxring_pkg::*;
#(
  parameter int PAGES     = 8,
  parameter int PG_W      = 4,
  parameter int LEN_W     = 11,
  parameter int MIN_FRAME = 60,
  parameter int MIN_FREE  = 1518
)(
  input  logic [PG_W-1:0]  first_pg,
  input  logic [PG_W-1:0]  last_pg,
  input  logic [PG_W-1:0]  bnd_pg,
  input  logic [PG_W-1:0]  cur_pg,
  input  logic [LEN_W-1:0] frame_len,
  output logic             full,
  output logic [PG_W-1:0]  base_pg,
  output logic [PG_W-1:0]  nxt_pg,
  output logic [15:0]      tot_len
);

  localparam int FREE_PG = (MIN_FREE + 255) / 256;
  localparam logic signed [PG_W+1:0] FREE_PG_S = FREE_PG[PG_W+1:0];
  localparam logic [PG_W-1:0] END_PG = PG_W'(PAGES);
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_FRAME);

  logic signed [PG_W+1:0] f_e, l_e, b_e, c_e, avail;
  logic [LEN_W-1:0] pad_len;
  logic [15:0] need, nsum, span;

  always_comb begin
    f_e = $signed({2'b00, first_pg});
    l_e = $signed({2'b00, last_pg});
    b_e = $signed({2'b00, bnd_pg});
    c_e = $signed({2'b00, cur_pg});
    if (c_e < b_e) avail = b_e - c_e;
    else           avail = (l_e - f_e) - (c_e - b_e);
    full = (last_pg <= first_pg) || (avail < FREE_PG_S);

    base_pg = (cur_pg >= END_PG) ? first_pg : cur_pg;
    pad_len = (frame_len < MIN_LEN) ? MIN_LEN : frame_len;
    tot_len = {{(16-LEN_W){1'b0}}, pad_len} + 16'(HDR_BYTES);
    need    = (tot_len + 16'(TRAIL_BYTES) + 16'd255) >> 8;
    nsum    = {{(16-PG_W){1'b0}}, base_pg} + need;
    span    = {{(16-PG_W){1'b0}}, last_pg} - {{(16-PG_W){1'b0}}, first_pg};
    if (nsum >= {{(16-PG_W){1'b0}}, last_pg}) nsum = nsum - span;
    nxt_pg  = nsum[PG_W-1:0];
  end

endmodule

// File: rtl/rxring_ram.sv
module rxring_ram #(
  parameter int ADDR_W = 11
)(
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxring_pkg::*;
#(
  parameter int PAGES     = 8,
  parameter int MAX_FRAME = 1514,
  parameter int MIN_FRAME = 60,
  localparam int PG_W     = $clog2(PAGES) + 1,
  localparam int ADDR_W   = PG_W + 7,
  localparam int LEN_W    = $clog2(MAX_FRAME + 1)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              halt,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [ADDR_W-1:0] mem_raddr,
  output logic [7:0]        mem_rdata,
  output logic              rx_done,
  output logic [7:0]        rx_status
);

  localparam int BA_W = PG_W + 8;
  localparam int MIN_FREE = MAX_FRAME + HDR_BYTES;
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_FRAME);

  wr_state_e        st;
  logic [PG_W-1:0]  first_pg, last_pg, bnd_pg, cur_pg;
  logic [PG_W-1:0]  base_pg, calc_nxt, hdr_nxt;
  logic             full;
  logic [15:0]      calc_tot, tot_len;
  logic [BA_W-1:0]  wa, wa_inc, wa_adv;
  logic [1:0]       hcnt;
  logic [LEN_W-1:0] cnt, cnt_inc;
  logic [7:0]       hdr_status, hdr_byte, ram_wdata;
  logic             ram_we, load_cur;

  rxring_regs #(.PAGES(PAGES), .PG_W(PG_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .load_cur(load_cur), .cur_nxt(hdr_nxt),
    .first_pg(first_pg), .last_pg(last_pg), .bnd_pg(bnd_pg), .cur_pg(cur_pg),
    .rdata(cfg_rdata)
  );

  rxring_space #(.PAGES(PAGES), .PG_W(PG_W), .LEN_W(LEN_W),
                 .MIN_FRAME(MIN_FRAME), .MIN_FREE(MIN_FREE)) u_space (
    .first_pg(first_pg), .last_pg(last_pg), .bnd_pg(bnd_pg), .cur_pg(cur_pg),
    .frame_len(in_len), .full(full), .base_pg(base_pg), .nxt_pg(calc_nxt),
    .tot_len(calc_tot)
  );

  rxring_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(wa[ADDR_W-1:0]), .wdata(ram_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  // Byte address advance with wrap from the ring end back to its first page.
  always_comb begin
    wa_inc = wa + BA_W'(1);
    wa_adv = (wa_inc == {last_pg, 8'h00}) ? {first_pg, 8'h00} : wa_inc;
    cnt_inc = cnt + LEN_W'(1);
    case (hcnt)
      2'd0:    hdr_byte = hdr_status;
      2'd1:    hdr_byte = {{(8-PG_W){1'b0}}, hdr_nxt};
      2'd2:    hdr_byte = tot_len[7:0];
      default: hdr_byte = tot_len[15:8];
    endcase
    ram_we    = (st == S_HDR) || (st == S_PAD) || (st == S_DATA && in_valid);
    ram_wdata = (st == S_HDR) ? hdr_byte : (st == S_DATA) ? in_data : 8'h00;
    in_ready  = (st == S_DATA) || (st == S_DROP);
    load_cur  = (st == S_FIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      wa         <= '0;
      hcnt       <= '0;
      cnt        <= '0;
      hdr_status <= '0;
      hdr_nxt    <= '0;
      tot_len    <= '0;
      rx_done    <= 1'b0;
      rx_status  <= '0;
    end else begin
      rx_done <= 1'b0;
      case (st)
        S_IDLE: if (in_valid) begin
          if (halt || full) begin
            st <= S_DROP;
          end else begin
            wa         <= {base_pg, 8'h00};
            hdr_status <= STAT_GOOD | (in_data[0] ? STAT_GROUP : 8'h00);
            hdr_nxt    <= calc_nxt;
            tot_len    <= calc_tot;
            hcnt       <= '0;
            cnt        <= '0;
            st         <= S_HDR;
          end
        end
        S_HDR: begin
          wa   <= wa_adv;
          hcnt <= hcnt + 2'd1;
          if (hcnt == 2'd3) st <= S_DATA;
        end
        S_DATA: if (in_valid) begin
          wa  <= wa_adv;
          cnt <= cnt_inc;
          if (in_last) st <= (cnt_inc < MIN_LEN) ? S_PAD : S_FIN;
        end
        S_PAD: begin
          wa  <= wa_adv;
          cnt <= cnt_inc;
          if (cnt_inc >= MIN_LEN) st <= S_FIN;
        end
        S_FIN: begin
          rx_done   <= 1'b1;
          rx_status <= hdr_status;
          st        <= S_IDLE;
        end
        default: if (in_valid && in_last) st <= S_IDLE;
      endcase
    end
  end

  p_drop_nowrite_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_DROP) |-> !ram_we)
    else $error("refused frame wrote memory");

  p_hdr_len_r5: assert property (@(posedge clk) disable iff (rst)
    (st == S_HDR) |-> (tot_len >= 16'(MIN_FRAME + HDR_BYTES)))
    else $error("stored length below padded minimum");

  p_pad_done_r7: assert property (@(posedge clk) disable iff (rst)
    (st == S_FIN) |-> (cnt >= MIN_LEN))
    else $error("frame finished before minimum payload");

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done)
    else $error("done held longer than one cycle");

  p_cur_load_r9: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> (cur_pg == $past(hdr_nxt)))
    else $error("current page not advanced to next page");

endmodule

// File: tb/rxring_writer_test.sv
`timescale 1ns/1ps
module rxring_writer_test;

  localparam int PAGES = 8;
  localparam int AW = 11;
  localparam int LW = 11;
  localparam int MEMB = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic [7:0] cfg_rdata;
  logic halt = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = 8'd0;
  logic in_last = 1'b0;
  logic [LW-1:0] in_len = '0;
  logic [AW-1:0] mem_raddr = '0;
  logic [7:0] mem_rdata;
  logic rx_done;
  logic [7:0] rx_status;

  rxring_writer #(.PAGES(PAGES)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .halt(halt),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_len(in_len), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata), .rx_done(rx_done), .rx_status(rx_status)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  bit prev_done = 1'b0;

  logic [7:0] mdl_mem [MEMB];
  bit mdl_known [MEMB];
  int m_first = 0, m_last = 0, m_bnd = 0, m_cur = 0;
  int m_status = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Per-clock comparison against the rules of R9 and R10.
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_done) begin
        done_cnt++;
        if (prev_done) chk(1'b0, "R9 done pulse width", 2, 1);
      end
      if (!in_valid && in_ready) chk(1'b0, "R10 ready without frame", 1, 0);
      prev_done = rx_done;
    end
  end

  initial begin
    #(8 * 180000);
    errors++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [7:0] pbyte(input int first, input int seed, input int i);
    return (i == 0) ? 8'(first) : 8'((seed + 7 * i) & 255);
  endfunction

  task automatic cfg_wr(input int s, input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(s); cfg_wdata = 8'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input int s, output int v);
    @(negedge clk);
    cfg_sel = 2'(s);
    @(negedge clk);
    v = int'(cfg_rdata);
  endtask

  task automatic mput(inout int addr, input int v);
    mdl_mem[addr] = 8'(v);
    mdl_known[addr] = 1'b1;
    addr++;
    if (addr == m_last * 256) addr = m_first * 256;
  endtask

  // Behavioural model of one frame; returns whether it is accepted.
  task automatic model_frame(input int len, input int first, input int seed,
                             input bit hlt, output bit acc);
    int avail, plen, tot, nxt, addr;
    avail = (m_cur < m_bnd) ? (m_bnd - m_cur) : ((m_last - m_first) - (m_cur - m_bnd));
    acc = !(hlt || (m_last <= m_first) || (avail * 256 < 1518));
    if (acc) begin
      plen = (len < 60) ? 60 : len;
      tot = plen + 4;
      nxt = m_cur + (tot + 4 + 255) / 256;
      if (nxt >= m_last) nxt -= (m_last - m_first);
      m_status = 1 | (((first & 1) != 0) ? 32 : 0);
      addr = m_cur * 256;
      mput(addr, m_status);
      mput(addr, nxt);
      mput(addr, tot & 255);
      mput(addr, tot >> 8);
      for (int i = 0; i < plen; i++) mput(addr, (i < len) ? int'(pbyte(first, seed, i)) : 0);
      m_cur = nxt;
    end
  endtask

  task automatic send(input int len, input int first, input int seed, output int stall);
    bit r;
    stall = 0;
    @(negedge clk);
    in_len = LW'(len);
    for (int i = 0; i < len; i++) begin
      in_data = pbyte(first, seed, i);
      in_last = (i == len - 1);
      in_valid = 1'b1;
      forever begin
        r = in_ready;
        @(negedge clk);
        if (r) break;
        if (i == 0) stall++;
      end
    end
    in_valid = 1'b0;
    in_last = 1'b0;
  endtask

  task automatic mem_compare(input string req);
    int bad = 0, bad_a = -1, act = 0, exp = 0;
    for (int a = 0; a < MEMB; a++) begin
      if (mdl_known[a]) begin
        @(negedge clk);
        mem_raddr = AW'(a);
        @(negedge clk);
        if (mem_rdata !== mdl_mem[a]) begin
          bad++;
          if (bad_a < 0) begin bad_a = a; act = int'(mem_rdata); exp = int'(mdl_mem[a]); end
        end
      end
    end
    if (bad != 0) $display("  first mismatch at byte %0d (%0d bad)", bad_a, bad);
    chk(bad == 0, req, act, exp);
  endtask

  task automatic run_frame(input int len, input int first, input int seed, input string tag);
    bit acc;
    int d0, stall, v, w;
    model_frame(len, first, seed, halt, acc);
    d0 = done_cnt;
    send(len, first, seed, stall);
    chk(stall == (acc ? 5 : 1), {tag, " R10 stall cycles"}, stall, acc ? 5 : 1);
    w = 0;
    while (w < 100 && done_cnt == d0) begin @(negedge clk); w++; end
    repeat (4) @(negedge clk);
    chk(done_cnt - d0 == (acc ? 1 : 0), {tag, " R9 done count"}, done_cnt - d0, acc ? 1 : 0);
    if (acc) chk(int'(rx_status) == m_status, {tag, " R6 status"}, int'(rx_status), m_status);
    cfg_rd(3, v);
    chk(v == m_cur, {tag, " R9 current page"}, v, m_cur);
    mem_compare({tag, " R5/R7/R8 memory image"});
  endtask

  initial begin
    int v;
    for (int a = 0; a < MEMB; a++) begin mdl_mem[a] = 8'h00; mdl_known[a] = 1'b0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // Reset state.
    chk(in_ready == 1'b0, "R10 ready after reset", int'(in_ready), 0);
    chk(rx_done == 1'b0, "R9 done after reset", int'(rx_done), 0);
    for (int s = 0; s < 4; s++) begin
      cfg_rd(s, v);
      chk(v == 0, "R1 register reset", v, 0);
    end

    // R2: empty configuration (last page not above first).
    run_frame(40, 8'h00, 3, "F0 R2");

    // R1: programming and range filter.
    cfg_wr(0, 1); cfg_wr(1, 8); cfg_wr(2, 1); cfg_wr(3, 1);
    m_first = 1; m_last = 8; m_bnd = 1; m_cur = 1;
    cfg_rd(0, v); chk(v == 1, "R1 first page", v, 1);
    cfg_rd(1, v); chk(v == 8, "R1 last page equal to PAGES", v, 8);
    cfg_wr(1, 9); cfg_rd(1, v); chk(v == 8, "R1 last page over range ignored", v, 8);
    cfg_wr(0, 9); cfg_rd(0, v); chk(v == 1, "R1 first page over range ignored", v, 1);
    cfg_wr(2, 8); cfg_rd(2, v); chk(v == 1, "R1 boundary at PAGES ignored", v, 1);
    cfg_wr(3, 8); cfg_rd(3, v); chk(v == 1, "R1 current at PAGES ignored", v, 1);

    // Short group frame, padded (R6, R7).
    run_frame(20, 8'h01, 11, "F1 R7");
    // Free space exactly 6 pages: accepted (R3 boundary).
    run_frame(100, 8'h00, 29, "F2 R3");
    // Free space 5 pages: refused (R3).
    run_frame(64, 8'h00, 5, "F3 R3");

    cfg_wr(2, 3); m_bnd = 3;
    run_frame(600, 8'h02, 41, "F4 R9");

    // Payload wraps past the ring end (R8) and next page wraps (R9).
    cfg_wr(2, 6); m_bnd = 6;
    run_frame(700, 8'h03, 57, "F5 R8");

    // Halted frame aimed at live data must not overwrite it (R4).
    cfg_wr(2, 2); m_bnd = 2;
    halt = 1'b1;
    run_frame(80, 8'h05, 77, "F6 R4");
    halt = 1'b0;

    // Largest frame.
    run_frame(1514, 8'h10, 91, "F7 R5");

    // Exactly 60 bytes: no padding, broadcast-style first byte.
    cfg_wr(2, 1); m_bnd = 1;
    run_frame(60, 8'hff, 13, "F8 R7");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule